// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block arbitrates six interrupt sources for a small 8-bit controller core: two external pins, two timer overflow flags, a combined serial flag and a combined timer-2 flag. Software writes an enable register and a priority register through a simple write port. The enable register has a global gate and one bit per source. The priority register puts each source on a high or a low level. Request flags are captured on a machine-cycle strobe. The captured values are arbitrated at the next strobe. A winner produces a held vector request with a fixed call address, and the CPU acknowledges it.

The controller records which priority levels have a service routine running. A return-from-interrupt strobe retires the highest running level. A vector is suppressed when a service of the same or a higher level is running, when the CPU is not in the last cycle of an instruction, or when the current instruction is a return-from-interrupt or a write to either register. A request that loses for any of these reasons is not stored. It is seen again only if its flag is still present at a later strobe. Each external source has its own flag with a selectable edge or level mode. The timer flags are owned outside the block, which tells their owner to clear them through one-cycle clear pulses.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, vec_req is 0, in_prog is 0, en_reg and pri_reg are 0, and both external flags are 0.
- R2: A write with reg_sel=0 loads en_reg, keeping bit 7 (global gate) and bits 5:0 and reading bit 6 as 0. A write with reg_sel=1 loads pri_reg bits 5:0 and reads bits 7:6 as 0. A 1 in pri_reg bit i makes source i high level.
- R3: A flag that first appears at a strobe is not acted on at that strobe. The earliest vector is issued at the following strobe, and vec_req is 1 in the clock after that strobe edge.
- R4: Source indices are 0 ext0, 1 timer0, 2 ext1, 3 timer1, 4 serial, 5 timer-2. The vector address of source i is 0x0003 + 8*i.
- R5: Among candidates, any high-level source wins over every low-level source. Within one level, the lowest index wins.
- R6: A source is a candidate only if its en_reg bit (bit i) is 1 and en_reg bit 7 is 1.
- R7: A low-level request is vectored only when in_prog is 0. A high-level request is vectored only when in_prog bit 1 is 0. in_prog bit 0 marks a running low-level service and bit 1 marks a running high-level service.
- R8: At a strobe where instr_last is 0 or instr_blk is 1, no vector is issued.
- R9: A request that is denied and has gone by a later strobe is never vectored.
- R10: In level mode (ext_edge=0), the external flag takes the inverted pin at each strobe and is not cleared by vectoring. In edge mode, a high sample followed by a low sample at the next strobe sets the flag, vectoring that source clears it, and a pin that stays low does not set it again.
- R11: Vectoring timer0 or timer1 pulses tmr_clr bit 0 or bit 1 for one clock. Serial and timer-2 vectors give no clear pulse.
- R12: vec_req stays 1 with a stable vec_addr until vec_ack. No new vector is decided while vec_req is 1.
- R13: reti_strobe clears in_prog bit 1 if it is set, and otherwise clears bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_strobe | input | 1 | Late-phase machine-cycle strobe: sample and poll point |
| instr_last | input | 1 | Current cycle is the final cycle of the instruction |
| instr_blk | input | 1 | Current instruction is a return-from-interrupt or a register write |
| reg_wr | input | 1 | Register write enable |
| reg_sel | input | 1 | 0 selects the enable register, 1 selects the priority register |
| reg_wdata | input | 8 | Register write data |
| ext_pin_n | input | 2 | External request pins, active low |
| ext_edge | input | 2 | Per external source: 1 edge mode, 0 level mode |
| tmr_flag | input | 2 | Timer0 and timer1 overflow flags |
| ser_flag | input | 1 | Serial receive-or-transmit flag |
| t2_flag | input | 1 | Timer-2 overflow-or-capture flag |
| vec_ack | input | 1 | CPU accepts the pending vector |
| reti_strobe | input | 1 | Return-from-interrupt executed |
| vec_req | output | 1 | Vector request |
| vec_addr | output | 16 | Call address of the pending vector |
| tmr_clr | output | 2 | One-clock clear pulses for timer0 and timer1 flags |
| ext_flag | output | 2 | External request flags |
| en_reg | output | 8 | Enable register contents |
| pri_reg | output | 8 | Priority register contents |
| in_prog | output | 2 | Running service levels: bit 0 low, bit 1 high |

## Verification
Assertions check several rules on every cycle. A held request keeps a stable address of the right form until it is acknowledged. A new vector always follows a strobe taken in a final instruction cycle with no block and with the global gate open. No vector appears while a high-level service is running. A return retires the top level. A level-mode flag tracks its pin. The bench scenarios are needed for the rest: the one-strobe latency between capture and decision, the order inside and across levels, preemption of a low service by a high one, loss of a request that was denied, edge detection with its clear on vectoring, and the clear pulses per source. Random masks and flag patterns are compared with a priority model in the bench.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC       = 6;
    localparam int NEXT       = 2;
    localparam int SRC_W      = $clog2(NSRC);
    localparam int ADDR_W     = 16;
    localparam int REG_W      = 8;
    localparam int GLOBAL_BIT = 7;
    localparam int VEC_STRIDE = 8;
    localparam logic [ADDR_W-1:0] VEC_BASE = 16'h0003;
    localparam logic [REG_W-1:0] EN_MASK  = REG_W'((1 << GLOBAL_BIT) | ((1 << NSRC) - 1));
    localparam logic [REG_W-1:0] PRI_MASK = REG_W'((1 << NSRC) - 1);

    typedef enum logic {LVL_LOW = 1'b0, LVL_HIGH = 1'b1} level_e;

    typedef struct packed {
        logic             found;
        logic [SRC_W-1:0] idx;
    } first_t;

    typedef struct packed {
        logic             valid;
        level_e           lvl;
        logic [SRC_W-1:0] idx;
    } pick_t;

    function automatic first_t first_set(input logic [NSRC-1:0] m);
        first_t r;
        r = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (m[i]) begin
                r.found = 1'b1;
                r.idx   = SRC_W'(i);
            end
        end
        return r;
    endfunction

    function automatic logic [ADDR_W-1:0] vec_addr_of(input logic [SRC_W-1:0] idx);
        return VEC_BASE + (ADDR_W'(idx) * ADDR_W'(VEC_STRIDE));
    endfunction
endpackage

// File: rtl/irq_ext_latch.sv
module irq_ext_latch (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic flag_d,
    output logic flag
);
    logic prev_q;
    logic flag_q;

    always_comb begin
        flag_d = flag_q;
        if (strobe) begin
            if (!edge_mode)
                flag_d = ~pin_n;
            else if (prev_q && !pin_n)
                flag_d = 1'b1;
        end
        if (clr && edge_mode)
            flag_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (strobe)
                prev_q <= pin_n;
            flag_q <= flag_d;
        end
    end

    assign flag = flag_q;

    assert_level_follows_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(strobe && !edge_mode)) |-> (flag_q == !$past(pin_n)));

    assert_edge_sets_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(strobe && edge_mode && prev_q && !pin_n && !clr)) |-> flag_q);
endmodule

// File: rtl/irq_poll_select.sv
module irq_poll_select
    import irq_pkg::*;
(
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] en_mask,
    input  logic            global_en,
    input  logic [NSRC-1:0] pri,
    input  logic [1:0]      prog,
    input  logic            allow,
    output pick_t           pick
);
    logic [NSRC-1:0] cand, hi, lo;
    first_t hf, lf;

    always_comb begin
        cand = (allow && global_en) ? (pend & en_mask) : '0;
        hi   = cand & pri;
        lo   = cand & ~pri;
        hf   = first_set(hi);
        lf   = first_set(lo);
        pick = '0;
        if (hf.found && !prog[1]) begin
            pick.valid = 1'b1;
            pick.lvl   = LVL_HIGH;
            pick.idx   = hf.idx;
        end else if (lf.found && prog == 2'b00) begin
            pick.valid = 1'b1;
            pick.lvl   = LVL_LOW;
            pick.idx   = lf.idx;
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_strobe,
    input  logic              instr_last,
    input  logic              instr_blk,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [NEXT-1:0]   ext_pin_n,
    input  logic [NEXT-1:0]   ext_edge,
    input  logic [NEXT-1:0]   tmr_flag,
    input  logic              ser_flag,
    input  logic              t2_flag,
    input  logic              vec_ack,
    input  logic              reti_strobe,
    output logic              vec_req,
    output logic [ADDR_W-1:0] vec_addr,
    output logic [NEXT-1:0]   tmr_clr,
    output logic [NEXT-1:0]   ext_flag,
    output logic [REG_W-1:0]  en_reg,
    output logic [REG_W-1:0]  pri_reg,
    output logic [1:0]        in_prog
);
    logic [REG_W-1:0]  en_q, pri_q;
    logic [NSRC-1:0]   snap_q, src_now;
    logic              req_q;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        prog_q;
    logic [NEXT-1:0]   tclr_q;
    logic [NEXT-1:0]   ext_d;
    pick_t             pick;
    logic              issue;

    irq_poll_select u_sel (
        .pend      (snap_q),
        .en_mask   (en_q[NSRC-1:0]),
        .global_en (en_q[GLOBAL_BIT]),
        .pri       (pri_q[NSRC-1:0]),
        .prog      (prog_q),
        .allow     (instr_last && !instr_blk),
        .pick      (pick)
    );

    assign issue = cyc_strobe && !req_q && pick.valid;

    for (genvar g = 0; g < NEXT; g++) begin : g_ext
        localparam int EXT_IDX = 2 * g;
        irq_ext_latch u_ext (
            .clk       (clk),
            .rst       (rst),
            .strobe    (cyc_strobe),
            .pin_n     (ext_pin_n[g]),
            .edge_mode (ext_edge[g]),
            .clr       (issue && pick.idx == SRC_W'(EXT_IDX)),
            .flag_d    (ext_d[g]),
            .flag      (ext_flag[g])
        );
        assign src_now[EXT_IDX]     = ext_d[g];
        assign src_now[EXT_IDX + 1] = tmr_flag[g];
    end
    assign src_now[2*NEXT]     = ser_flag;
    assign src_now[2*NEXT + 1] = t2_flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pri_q  <= '0;
            snap_q <= '0;
            req_q  <= 1'b0;
            addr_q <= '0;
            prog_q <= '0;
            tclr_q <= '0;
        end else begin
            tclr_q <= '0;
            if (reg_wr) begin
                if (!reg_sel) en_q  <= reg_wdata & EN_MASK;
                else          pri_q <= reg_wdata & PRI_MASK;
            end
            if (cyc_strobe)
                snap_q <= src_now;
            if (req_q && vec_ack)
                req_q <= 1'b0;
            if (reti_strobe) begin
                if (prog_q[1]) prog_q[1] <= 1'b0;
                else           prog_q[0] <= 1'b0;
            end
            if (issue) begin
                req_q  <= 1'b1;
                addr_q <= vec_addr_of(pick.idx);
                if (pick.lvl == LVL_HIGH) prog_q[1] <= 1'b1;
                else                      prog_q[0] <= 1'b1;
                for (int g = 0; g < NEXT; g++)
                    tclr_q[g] <= (pick.idx == SRC_W'(2 * g + 1));
            end
        end
    end

    assign vec_req  = req_q;
    assign vec_addr = addr_q;
    assign tmr_clr  = tclr_q;
    assign en_reg   = en_q;
    assign pri_reg  = pri_q;
    assign in_prog  = prog_q;

    assert_req_held_R12: assert property (@(posedge clk) disable iff (rst)
        (vec_req && !vec_ack) |=> (vec_req && $stable(vec_addr)));

    assert_vec_addr_R4: assert property (@(posedge clk) disable iff (rst)
        vec_req |-> (vec_addr[2:0] == 3'd3 && vec_addr <= vec_addr_of(SRC_W'(NSRC - 1))));

    assert_block_rules_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(vec_req) |-> $past(cyc_strobe && instr_last && !instr_blk));

    assert_global_gate_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(vec_req) |-> $past(en_q[GLOBAL_BIT]));

    assert_high_not_preempted_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(vec_req) |-> !$past(prog_q[1]));

    assert_reti_high_R13: assert property (@(posedge clk) disable iff (rst)
        (reti_strobe && prog_q[1]) |=> !prog_q[1]);

    assert_reti_low_R13: assert property (@(posedge clk) disable iff (rst)
        (reti_strobe && prog_q == 2'b01 && !cyc_strobe) |=> (prog_q == 2'b00));
endmodule

// File: tb/irq_arbiter_bench.sv
module irq_arbiter_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc_strobe = 0, instr_last = 0, instr_blk = 0;
    logic        reg_wr = 0, reg_sel = 0;
    logic [7:0]  reg_wdata = '0;
    logic [1:0]  ext_pin_n = 2'b11, ext_edge = 2'b00, tmr_flag = 2'b00;
    logic        ser_flag = 0, t2_flag = 0, vec_ack = 0, reti_strobe = 0;
    logic        vec_req;
    logic [15:0] vec_addr;
    logic [1:0]  tmr_clr, ext_flag, in_prog;
    logic [7:0]  en_reg, pri_reg;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_arbiter u_irq_arbiter (
        .clk(clk), .rst(rst), .cyc_strobe(cyc_strobe), .instr_last(instr_last),
        .instr_blk(instr_blk), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .ext_pin_n(ext_pin_n), .ext_edge(ext_edge), .tmr_flag(tmr_flag),
        .ser_flag(ser_flag), .t2_flag(t2_flag), .vec_ack(vec_ack),
        .reti_strobe(reti_strobe), .vec_req(vec_req), .vec_addr(vec_addr),
        .tmr_clr(tmr_clr), .ext_flag(ext_flag), .en_reg(en_reg), .pri_reg(pri_reg),
        .in_prog(in_prog)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic mcyc(input logic last, input logic blk);
        @(negedge clk);
        cyc_strobe = 1; instr_last = last; instr_blk = blk;
        @(negedge clk);
        cyc_strobe = 0; instr_last = 0; instr_blk = 0;
    endtask

    task automatic wreg(input logic sel, input logic [7:0] d);
        @(negedge clk); reg_wr = 1; reg_sel = sel; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic ack();
        @(negedge clk); vec_ack = 1;
        @(negedge clk); vec_ack = 0;
    endtask

    task automatic reti();
        @(negedge clk); reti_strobe = 1;
        @(negedge clk); reti_strobe = 0;
    endtask

    function automatic int exp_pick(input logic [7:0] en, input logic [7:0] pri, input logic [5:0] pend);
        logic [5:0] cand;
        cand = en[7] ? (pend & en[5:0]) : 6'd0;
        for (int i = 0; i < 6; i++) if (cand[i] && pri[i]) return i;
        for (int i = 0; i < 6; i++) if (cand[i] && !pri[i]) return i;
        return -1;
    endfunction

    task automatic drive_src(input logic [5:0] p);
        ext_pin_n[0] = ~p[0]; tmr_flag[0] = p[1];
        ext_pin_n[1] = ~p[2]; tmr_flag[1] = p[3];
        ser_flag = p[4]; t2_flag = p[5];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 vec_req", 16'(vec_req), 0);
        chk("R1 in_prog", 16'(in_prog), 0);
        chk("R1 en_reg", 16'(en_reg), 0);
        chk("R1 pri_reg", 16'(pri_reg), 0);
        chk("R1 ext_flag", 16'(ext_flag), 0);

        wreg(0, 8'hFF); chk("R2 enable mask", 16'(en_reg), 16'hBF);
        wreg(1, 8'hFF); chk("R2 priority mask", 16'(pri_reg), 16'h3F);
        wreg(1, 8'h00); chk("R2 priority clear", 16'(pri_reg), 0);

        // level-mode ext0
        wreg(0, 8'h81);
        ext_pin_n[0] = 0;
        mcyc(1, 0);
        chk("R3 no vector at capture strobe", 16'(vec_req), 0);
        chk("R10 level flag set", 16'(ext_flag[0]), 1);
        mcyc(1, 0);
        chk("R3 vector next strobe", 16'(vec_req), 1);
        chk("R4 ext0 address", vec_addr, 16'h0003);
        chk("R7 low in progress", 16'(in_prog), 16'b01);
        mcyc(1, 0);
        chk("R10 level flag kept", 16'(ext_flag[0]), 1);
        chk("R12 held", 16'(vec_req), 1);
        chk("R12 address stable", vec_addr, 16'h0003);
        ack();
        chk("R12 ack drops request", 16'(vec_req), 0);
        mcyc(1, 0);
        chk("R7 equal level blocked", 16'(vec_req), 0);
        ext_pin_n[0] = 1;
        mcyc(1, 0);
        chk("R10 level flag follows pin", 16'(ext_flag[0]), 0);
        reti();
        chk("R13 reti clears low", 16'(in_prog), 0);
        mcyc(1, 0);
        chk("R9 released flag no vector", 16'(vec_req), 0);

        // denied, then gone
        ext_pin_n[0] = 0; mcyc(0, 0);
        ext_pin_n[0] = 1; mcyc(0, 0);
        chk("R8 not final cycle", 16'(vec_req), 0);
        mcyc(1, 0);
        chk("R9 denied request forgotten", 16'(vec_req), 0);

        // blocking instruction
        ext_pin_n[0] = 0; mcyc(1, 1);
        mcyc(1, 1);
        chk("R8 blocking instruction", 16'(vec_req), 0);
        mcyc(1, 0);
        chk("R8 vector after block lifts", 16'(vec_req), 1);
        ack(); ext_pin_n[0] = 1; mcyc(0, 0); mcyc(0, 0); reti();

        // global gate
        wreg(0, 8'h01);
        ext_pin_n[0] = 0; mcyc(1, 0); mcyc(1, 0);
        chk("R6 global gate closed", 16'(vec_req), 0);
        wreg(0, 8'h80); mcyc(1, 0);
        chk("R6 source bit closed", 16'(vec_req), 0);
        ext_pin_n[0] = 1; mcyc(0, 0); mcyc(0, 0);

        // timers, serial, levels
        wreg(0, 8'hBF); wreg(1, 8'h08);
        tmr_flag = 2'b11; ser_flag = 1;
        mcyc(1, 0); mcyc(1, 0);
        chk("R5 high wins", vec_addr, 16'h001B);
        chk("R7 high in progress", 16'(in_prog), 16'b10);
        chk("R11 timer1 clear", 16'(tmr_clr), 16'b10);
        ack(); tmr_flag[1] = 0;
        mcyc(1, 0);
        chk("R7 high not preempted", 16'(vec_req), 0);
        reti();
        mcyc(1, 0);
        chk("R5 timer0 before serial", vec_addr, 16'h000B);
        chk("R11 timer0 clear", 16'(tmr_clr), 16'b01);
        ack(); tmr_flag[0] = 0;
        tmr_flag[1] = 1;
        mcyc(1, 0);
        chk("R7 low blocked by low", 16'(vec_req), 0);
        mcyc(1, 0);
        chk("R7 high preempts low", vec_addr, 16'h001B);
        chk("R7 both levels", 16'(in_prog), 16'b11);
        ack(); tmr_flag[1] = 0; mcyc(0, 0);
        reti();
        chk("R13 reti clears high first", 16'(in_prog), 16'b01);
        reti();
        chk("R13 reti clears low", 16'(in_prog), 0);
        mcyc(1, 0);
        chk("R4 serial address", vec_addr, 16'h0023);
        chk("R11 serial no clear", 16'(tmr_clr), 0);
        ack(); reti();
        mcyc(1, 0);
        chk("R11 serial still pending", 16'(vec_req), 1);
        ack(); ser_flag = 0; mcyc(0, 0); reti();

        // edge-mode ext1
        wreg(0, 8'h84); wreg(1, 8'h00);
        ext_edge[1] = 1;
        ext_pin_n[1] = 1; mcyc(0, 0);
        ext_pin_n[1] = 0; mcyc(0, 0);
        chk("R10 edge sets flag", 16'(ext_flag[1]), 1);
        mcyc(1, 0);
        chk("R4 ext1 address", vec_addr, 16'h0013);
        chk("R10 edge flag cleared by vector", 16'(ext_flag[1]), 0);
        ack(); reti();
        mcyc(1, 0); mcyc(1, 0);
        chk("R10 steady low no new edge", 16'(vec_req), 0);
        ext_pin_n[1] = 1; ext_edge[1] = 0; mcyc(0, 0);

        // full order inside one level
        wreg(0, 8'hBF); wreg(1, 8'h00);
        drive_src(6'h3F);
        mcyc(0, 0);
        for (int i = 0; i < 6; i++) begin
            logic [5:0] rest;
            mcyc(1, 0);
            chk("R5 order within level", vec_addr, 16'(3 + 8 * i));
            ack();
            rest = 6'h3F << (i + 1);
            drive_src(rest);
            mcyc(0, 0);
            reti();
        end
        drive_src(6'h00); mcyc(0, 0);

        // random masks and flags
        void'($urandom(32'd2024));
        for (int n = 0; n < 40; n++) begin
            logic [7:0] en, pri;
            logic [5:0] pend;
            int e;
            en   = {($urandom % 4) != 0, 1'b0, 6'($urandom)};
            pri  = {2'b00, 6'($urandom)};
            pend = 6'($urandom);
            wreg(0, en); wreg(1, pri);
            drive_src(pend);
            mcyc(0, 0); mcyc(1, 0);
            e = exp_pick(en, pri, pend);
            chk("R5 random vector present", 16'(vec_req), (e >= 0) ? 16'd1 : 16'd0);
            if (e >= 0) chk("R5 random vector address", vec_addr, 16'(3 + 8 * e));
            drive_src(6'h00);
            ack(); mcyc(0, 0); mcyc(0, 0);
            if (e >= 0) reti();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule